// File: doc/BRIEF.md
# Interrupt Enable and Flag Register

This block is the interrupt control register of a small microcontroller core. One 8-bit storage word holds a global enable, an enable for the peripheral group, three per-source enables and three sticky per-source flags. The three local sources are an overflow pulse from a timer, an external interrupt pin, and a change on any of four port pins. The block merges all of these into one interrupt request for the core. Peripheral sources keep their own enables and flags outside this block, which sees them as a single request input.

A flag is latched by its event whatever the enables hold. Once set, a flag stays set until software writes it to 0. The core reaches the register through a simple single-cycle bus: a write takes effect at the next clock edge, and a read returns the stored word combinationally. Two bus addresses select the same storage. The bus never stalls and has no back-pressure, so it carries no valid/ready handshake. All other pins are plain level or pulse signals.

The external pin and the port pins are asynchronous to the core clock. Each passes through a two-flop synchronizer before edge or change detection. A snapshot register holds the last synchronized port value for the change comparison.

Top module: `irq_ctl_reg`

## Requirements
- R1: Register bit positions are: bit 7 global enable, bit 6 peripheral enable, bit 5 timer enable, bit 4 pin enable, bit 3 port enable, bit 2 timer flag, bit 1 pin flag, bit 0 port flag. A bus write to the register stores all 8 data bits at the next clock edge, and a read returns the stored word.
- R2: Addresses 0x0B and 0x8B select the same storage. Any other address reads 0x00, and a write to it leaves the register unchanged.
- R3: While reset is asserted and after its release, the register reads 0x00 and the interrupt request is 0.
- R4: The interrupt request equals global enable AND ((timer enable AND timer flag) OR (pin enable AND pin flag) OR (port enable AND port flag) OR (peripheral enable AND peripheral request)). It is combinational from the stored bits.
- R5: While the global enable is 0, the interrupt request is 0, whatever the flags, the other enables and the peripheral request hold.
- R6: The peripheral request reaches the interrupt request only while the peripheral enable is 1.
- R7: A one-cycle timer overflow pulse sets the timer flag at the clock edge where it is sampled, whatever the enables hold.
- R8: A rising edge on the external pin sets the pin flag, whatever the enables hold. The flag reads 1 after the third clock edge that follows the change (two synchronizer stages plus the edge compare). A falling edge does not set the flag.
- R9: A change on any of the four port pins sets the port flag after the third clock edge that follows the change. Pins held steady do not set it.
- R10: Flags are sticky. No hardware action clears a flag; only a bus write of 0 to that bit clears it.
- R11: When a hardware event and a bus write of 0 hit the same flag in the same cycle, the flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Bus address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0x00 when the address does not select the register |
| tmr_ovf_pulse | input | 1 | Timer overflow event, one-cycle pulse |
| ext_pin | input | 1 | External interrupt pin, asynchronous |
| port_pins | input | 4 | Watched port pins, asynchronous |
| periph_req | input | 1 | Combined request of the peripheral group |
| irq_out | output | 1 | Interrupt request to the core |

## Verification
The hardest case is a hardware set colliding with a software clear in the same cycle. For the pin and port flags, the event arrives three edges after the pin moves, so the bench has to line the write strobe up with the synchronizer delay. The directed part does this for the timer pulse, where the pulse and the write are driven on the same falling edge. A long random phase then changes the pins, the pulses and writes to both mirror addresses and to a non-matching address every cycle. A cycle-accurate reference model covers the collisions that land on the synchronized sources.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

  localparam int unsigned CTL_W = 8;

  // Field order is software-visible: MSB first.
  typedef struct packed {
    logic gen_en;     // bit 7
    logic grp_en;     // bit 6
    logic tmr_en;     // bit 5
    logic pin_en;     // bit 4
    logic prt_en;     // bit 3
    logic tmr_flg;    // bit 2
    logic pin_flg;    // bit 1
    logic prt_flg;    // bit 0
  } irq_ctl_t;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d_async;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= '0;
      else        stg[i] <= stg[i-1];
    end
  end

  assign d_sync = stg[STAGES-1];

endmodule

// File: rtl/irq_evt_detect.sv
module irq_evt_detect #(
  parameter int unsigned PORT_W   = 4,
  parameter bit          PIN_RISE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_s,
  input  logic [PORT_W-1:0] port_s,
  output logic              pin_evt,
  output logic              port_evt
);

  logic              pin_prev;
  logic [PORT_W-1:0] port_snap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_prev  <= 1'b0;
      port_snap <= '0;
    end else begin
      pin_prev  <= pin_s;
      port_snap <= port_s;
    end
  end

  if (PIN_RISE) begin : g_rise
    assign pin_evt = pin_s & ~pin_prev;
  end else begin : g_fall
    assign pin_evt = ~pin_s & pin_prev;
  end

  assign port_evt = |(port_s ^ port_snap);

endmodule

// File: rtl/irq_ctl_store.sv
module irq_ctl_store
  import irq_ctl_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  irq_ctl_t wr_val,
  input  logic     tmr_evt,
  input  logic     pin_evt,
  input  logic     port_evt,
  output irq_ctl_t ctl_q
);

  irq_ctl_t ctl_d;

  always_comb begin
    ctl_d = wr_en ? wr_val : ctl_q;
    // A hardware event outranks a software clear in the same cycle.
    ctl_d.tmr_flg = ctl_d.tmr_flg | tmr_evt;
    ctl_d.pin_flg = ctl_d.pin_flg | pin_evt;
    ctl_d.prt_flg = ctl_d.prt_flg | port_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

endmodule

// File: rtl/irq_req_combine.sv
module irq_req_combine
  import irq_ctl_pkg::*;
(
  input  irq_ctl_t ctl,
  input  logic     grp_req,
  output logic     irq
);

  logic local_any;
  logic grp_any;

  assign local_any = (ctl.tmr_en & ctl.tmr_flg)
                   | (ctl.pin_en & ctl.pin_flg)
                   | (ctl.prt_en & ctl.prt_flg);
  assign grp_any   = ctl.grp_en & grp_req;
  assign irq       = ctl.gen_en & (local_any | grp_any);

endmodule

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg
  import irq_ctl_pkg::*;
#(
  parameter int unsigned      ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] ADDR_LO    = 8'h0B,
  parameter logic [ADDR_W-1:0] ADDR_HI    = 8'h8B,
  parameter int unsigned      PORT_W      = 4,
  parameter int unsigned      SYNC_STAGES = 2,
  parameter bit               PIN_RISE    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [CTL_W-1:0]  bus_wdata,
  output logic [CTL_W-1:0]  bus_rdata,
  input  logic              tmr_ovf_pulse,
  input  logic              ext_pin,
  input  logic [PORT_W-1:0] port_pins,
  input  logic              periph_req,
  output logic              irq_out
);

  logic              sel;
  logic              pin_s;
  logic [PORT_W-1:0] port_s;
  logic              pin_evt;
  logic              port_evt;
  irq_ctl_t          ctl_q;

  assign sel = (bus_addr == ADDR_LO) || (bus_addr == ADDR_HI);

  irq_sync #(.W(1), .STAGES(SYNC_STAGES)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d_async(ext_pin), .d_sync(pin_s)
  );

  irq_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_port_sync (
    .clk(clk), .rst_n(rst_n), .d_async(port_pins), .d_sync(port_s)
  );

  irq_evt_detect #(.PORT_W(PORT_W), .PIN_RISE(PIN_RISE)) u_evt (
    .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .port_s(port_s),
    .pin_evt(pin_evt), .port_evt(port_evt)
  );

  irq_ctl_store u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bus_wr & sel), .wr_val(irq_ctl_t'(bus_wdata)),
    .tmr_evt(tmr_ovf_pulse), .pin_evt(pin_evt), .port_evt(port_evt),
    .ctl_q(ctl_q)
  );

  irq_req_combine u_comb (
    .ctl(ctl_q), .grp_req(periph_req), .irq(irq_out)
  );

  assign bus_rdata = sel ? ctl_q : '0;

endmodule

// File: rtl/irq_ctl_reg_chk.sv
module irq_ctl_reg_chk #(
  parameter int unsigned       ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] ADDR_LO = 8'h0B,
  parameter logic [ADDR_W-1:0] ADDR_HI = 8'h8B
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [7:0]        bus_wdata,
  input logic              tmr_ovf_pulse,
  input logic              periph_req,
  input logic              irq_out,
  input logic [7:0]        ctl_bits
);

  logic wr_hit;
  assign wr_hit = bus_wr && ((bus_addr == ADDR_LO) || (bus_addr == ADDR_HI));

  // R1: enables take the written value; flags hold at least the written 1s
  p_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (ctl_bits[7:3] == $past(bus_wdata[7:3])) &&
               ((ctl_bits[2:0] & $past(bus_wdata[2:0])) == $past(bus_wdata[2:0])));

  // R2: a write elsewhere leaves the enables unchanged
  p_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(ctl_bits[7:3]));

  // R3: register is clear on the first edge after reset release
  p_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ctl_bits == 8'h00) && !irq_out);

  // R5: global enable low blocks the request
  p_gen_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_bits[7] |-> !irq_out);

  // R6: enabled group request raises the request
  p_grp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_bits[7] && ctl_bits[6] && periph_req) |-> irq_out);

  // R7: timer pulse sets its flag
  p_tmr_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf_pulse |=> ctl_bits[2]);

  // R10: without a register write no flag falls
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> ((ctl_bits[2:0] & $past(ctl_bits[2:0])) == $past(ctl_bits[2:0])));

endmodule

bind irq_ctl_reg irq_ctl_reg_chk #(
  .ADDR_W(ADDR_W), .ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .tmr_ovf_pulse(tmr_ovf_pulse),
  .periph_req(periph_req), .irq_out(irq_out), .ctl_bits(ctl_q)
);

// File: tb/irq_ctl_reg_bench.sv
module irq_ctl_reg_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h0B;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       tmr_ovf_pulse = 1'b0;
  logic       ext_pin = 1'b0;
  logic [3:0] port_pins = 4'h0;
  logic       periph_req = 1'b0;
  logic       irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_ctl_reg u_irq_ctl_reg (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tmr_ovf_pulse(tmr_ovf_pulse), .ext_pin(ext_pin), .port_pins(port_pins),
    .periph_req(periph_req), .irq_out(irq_out)
  );

  // Behavioural reference: integer pipelines for the pin delays.
  int m_reg;
  int m_pin [3];   // [0],[1] sync stages, [2] previous value
  int m_port [3];  // [0],[1] sync stages, [2] snapshot

  function automatic bit m_sel(input logic [7:0] a);
    return (a == 8'h0B) || (a == 8'h8B);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg = 0;
      foreach (m_pin[i])  m_pin[i] = 0;
      foreach (m_port[i]) m_port[i] = 0;
    end else begin
      int nxt;
      nxt = (bus_wr && m_sel(bus_addr)) ? int'(bus_wdata) : m_reg;
      if (tmr_ovf_pulse)                 nxt = nxt | 4;
      if (m_pin[1] == 1 && m_pin[2] == 0) nxt = nxt | 2;
      if (m_port[1] != m_port[2])         nxt = nxt | 1;
      m_reg = nxt;
      m_pin[2] = m_pin[1];   m_pin[1] = m_pin[0];   m_pin[0] = int'(ext_pin);
      m_port[2] = m_port[1]; m_port[1] = m_port[0]; m_port[0] = int'(port_pins);
    end
  end

  function automatic int m_irq(input int r, input bit g);
    int any;
    any = 0;
    if (((r >> 5) & 1) && ((r >> 2) & 1)) any = 1;
    if (((r >> 4) & 1) && ((r >> 1) & 1)) any = 1;
    if (((r >> 3) & 1) && (r & 1))        any = 1;
    if (((r >> 6) & 1) && g)              any = 1;
    return ((r >> 7) & 1) ? any : 0;
  endfunction

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, got, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    #2;
    if (!done) begin
      check("R1 read word", int'(bus_rdata), m_sel(bus_addr) ? m_reg : 0);
      check("R4 request",   int'(irq_out),   m_irq(m_reg, periph_req));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    #1;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R3 reset read", int'(bus_rdata), 0);
    check("R3 reset irq",  int'(irq_out), 0);
    @(negedge clk); rst_n = 1'b1;
    step(2);
    check("R3 after release", int'(bus_rdata), 0);

    // R1 layout and write
    wr(8'h0B, 8'hA8);
    check("R1 write 0xA8", int'(bus_rdata), 8'hA8);
    check("R4 no flag no irq", int'(irq_out), 0);

    // R2 mirror and miss
    bus_addr = 8'h8B; #1;
    check("R2 mirror read", int'(bus_rdata), 8'hA8);
    wr(8'h8B, 8'h50);
    bus_addr = 8'h0B; #1;
    check("R2 mirror write", int'(bus_rdata), 8'h50);
    bus_addr = 8'h0C; #1;
    check("R2 miss reads zero", int'(bus_rdata), 0);
    wr(8'h0C, 8'hFF);
    bus_addr = 8'h0B; #1;
    check("R2 miss write ignored", int'(bus_rdata), 8'h50);

    // R7 with all enables off, R5 block
    wr(8'h0B, 8'h00);
    @(negedge clk); tmr_ovf_pulse = 1'b1;
    @(negedge clk); tmr_ovf_pulse = 1'b0; #1;
    check("R7 timer flag set", int'(bus_rdata), 8'h04);
    check("R5 disabled no irq", int'(irq_out), 0);
    step(5);
    check("R10 flag sticky", int'(bus_rdata), 8'h04);
    wr(8'h0B, 8'hA4);
    check("R4 timer irq", int'(irq_out), 1);
    wr(8'h0B, 8'hA0);
    check("R10 write clears", int'(bus_rdata), 8'hA0);
    check("R10 irq drops", int'(irq_out), 0);

    // R8 pin rising edge, latency three edges
    wr(8'h0B, 8'h00);
    @(negedge clk); ext_pin = 1'b1;
    step(2);
    check("R8 not yet after two edges", int'(bus_rdata[1]), 0);
    step(1);
    check("R8 set after third edge", int'(bus_rdata[1]), 1);
    ext_pin = 1'b0;
    step(6);
    wr(8'h0B, 8'h00);
    step(5);
    check("R8 falling edge ignored", int'(bus_rdata), 0);

    // R9 port change
    @(negedge clk); port_pins = 4'b0100;
    step(2);
    check("R9 not yet", int'(bus_rdata[0]), 0);
    step(1);
    check("R9 change sets", int'(bus_rdata[0]), 1);
    wr(8'h0B, 8'h00);
    step(5);
    check("R9 steady no set", int'(bus_rdata), 0);
    @(negedge clk); port_pins = 4'b0110;
    step(3);
    check("R9 second change", int'(bus_rdata), 8'h01);

    // R6 group gating
    wr(8'h0B, 8'h80);
    periph_req = 1'b1; #1;
    check("R6 group masked", int'(irq_out), 0);
    wr(8'h0B, 8'hC0);
    check("R6 group passes", int'(irq_out), 1);
    wr(8'h0B, 8'h40);
    check("R5 global off", int'(irq_out), 0);
    periph_req = 1'b0;

    // R11 set beats clear
    wr(8'h0B, 8'h04);
    @(negedge clk);
    tmr_ovf_pulse = 1'b1; bus_wr = 1'b1; bus_addr = 8'h0B; bus_wdata = 8'h00;
    @(negedge clk);
    tmr_ovf_pulse = 1'b0; bus_wr = 1'b0; #1;
    check("R11 set wins", int'(bus_rdata), 8'h04);

    // R4 other terms
    wr(8'h0B, 8'h92);
    check("R4 pin term", int'(irq_out), 1);
    wr(8'h0B, 8'h89);
    check("R4 port term", int'(irq_out), 1);
    wr(8'h0B, 8'h81);
    check("R4 port masked", int'(irq_out), 0);

    // Random phase, model compared every cycle
    for (int i = 0; i < 3000; i++) begin
      int r;
      @(negedge clk);
      r = int'($urandom);
      case (r & 3)
        0: bus_addr = 8'h0B;
        1: bus_addr = 8'h8B;
        2: bus_addr = 8'h0C;
        default: bus_addr = 8'h0B;
      endcase
      bus_wr        = ((r >> 2) & 7) == 0;
      bus_wdata     = 8'(r >> 8);
      tmr_ovf_pulse = ((r >> 16) & 7) == 0;
      if (((r >> 19) & 3) == 0) ext_pin = ~ext_pin;
      if (((r >> 21) & 7) == 0) port_pins = 4'(r >> 24);
      periph_req    = ((r >> 28) & 1) == 1;
    end
    bus_wr = 1'b0; tmr_ovf_pulse = 1'b0;
    step(4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule